// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutation Controller

This block turns three digital Hall-sensor levels into the six gate enables of a three-phase bridge. Each phase has a high-side and a low-side enable. The controller takes a direction request, a coast (stop) request and a brake request. When coast and brake are asserted together, the controller enters a low-power standby. Thermal and undervoltage fault lines shut every switch off. An overvoltage line disables synchronous rectification.

A chop input gates the driven high-side switch. While chop is low, the low-side switch of that same phase is turned on, so the winding current decays slowly through the low-resistance channel. Every leg of the bridge passes through a dead-time stage. That stage keeps both switches of a leg off for a set number of cycles before the complementary switch turns on. The chop, direction, stop and brake inputs each pass through a glitch filter. The chop filter is shorter than the filter on the other three.

Top module: `bldc_commutator`

## Requirements
- R1: With dir_i=1, chop high and no overriding request, hall_i={HA,HB,HC} maps to one high-side and one low-side enable. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C. The mapping is: 101 gives A high and B low; 100 gives A high and C low; 110 gives B high and C low; 010 gives B high and A low; 011 gives C high and A low; 001 gives C high and B low.
- R2: With dir_i=0, the same six codes drive the same pair of phases with the high and low sides exchanged.
- R3: The Hall codes 000 and 111 turn all six enables off, even while brake is requested.
- R4: With stop high and brake low, all six enables are off whatever the chop level.
- R5: With brake high and stop low, on a valid Hall code, all three low-side enables are on and all high-side enables are off whatever the chop level.
- R6: With stop and brake both high, standby_o is 1 and all enables are off. Hall, direction, chop, overvoltage and fault inputs have no effect on the outputs in this state.
- R7: With chop low, the driven high-side enable is off. The low-side enable of that phase is on together with the low-side enable of the sink phase.
- R8: While ovp_i is high, the decay low-side switch of R7 stays off. Only the sink low-side enable remains on.
- R9: No leg ever has both enables on. After either switch of a leg turns off, both stay off for at least DEAD_CYC cycles before the other switch of that leg turns on.
- R10: A pulse on chop_i shorter than CHOP_FILT cycles has no effect. A pulse on dir_i, stop_i or brake_i shorter than CTRL_FILT cycles has no effect. A pulse held for the full length is accepted.
- R11: Asserting tsd_i or uv_i turns all enables off at the next clock edge. Normal drive returns once both inputs are clear.
- R12: During and right after reset, all enables are off and standby_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_i | input | 3 | Hall levels {HA,HB,HC}, synchronised |
| dir_i | input | 1 | 1 = forward, 0 = reverse |
| stop_i | input | 1 | Coast request |
| brake_i | input | 1 | Brake request |
| chop_i | input | 1 | Chop gate; low starts current decay |
| ovp_i | input | 1 | Overvoltage; disables synchronous rectification |
| tsd_i | input | 1 | Thermal shutdown fault |
| uv_i | input | 1 | Undervoltage fault |
| hs_en_o | output | 3 | High-side enables, bit 0 = phase A |
| ls_en_o | output | 3 | Low-side enables, bit 0 = phase A |
| standby_o | output | 1 | Standby active |

## Verification
The checker assumes the Hall code and the fault lines are already synchronous to the clock. This lets it relate an invalid code or a fault seen in one cycle to the outputs in the next cycle. The stimulus changes inputs only on the falling clock edge. Each random pattern is held for longer than the control filter plus twice the dead time, so every sampled output has reached its settled state. The glitch cases are the only ones that deliberately hold an input for less than a filter length.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

    localparam int unsigned PHASES = 3;

    typedef logic [1:0] phase_t;           // 0=A 1=B 2=C 3=none
    localparam phase_t PH_NONE = 2'd3;

    typedef struct packed {
        phase_t src;                       // phase whose high side drives
        phase_t snk;                       // phase whose low side sinks
    } pair_t;

    // Forward-direction driven pair for each Hall code
    function automatic pair_t fwd_pair(input logic [2:0] code);
        pair_t p;
        unique case (code)
            3'b101:  p = '{src: 2'd0, snk: 2'd1};
            3'b100:  p = '{src: 2'd0, snk: 2'd2};
            3'b110:  p = '{src: 2'd1, snk: 2'd2};
            3'b010:  p = '{src: 2'd1, snk: 2'd0};
            3'b011:  p = '{src: 2'd2, snk: 2'd0};
            3'b001:  p = '{src: 2'd2, snk: 2'd1};
            default: p = '{src: PH_NONE, snk: PH_NONE};
        endcase
        return p;
    endfunction

    function automatic logic [PHASES-1:0] phase_mask(input phase_t ph);
        logic [PHASES-1:0] m;
        m = '0;
        for (int i = 0; i < PHASES; i++) begin
            if (ph == phase_t'(i)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/bldc_glitch_filter.sv
module bldc_glitch_filter #(
    parameter int unsigned LEN     = 100,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.lvl = raw_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: RST_VAL, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flt_o = st_q.lvl;

endmodule

// File: rtl/bldc_commutation_table.sv
module bldc_commutation_table
    import bldc_pkg::*;
(
    input  logic              [2:0] hall_i,
    input  logic                    dir_f,
    input  logic                    stop_f,
    input  logic                    brake_f,
    input  logic                    chop_f,
    input  logic                    ovp_i,
    input  logic                    fault_i,
    output logic [PHASES-1:0]       want_hs_o,
    output logic [PHASES-1:0]       want_ls_o,
    output logic                    standby_o
);
    pair_t             fp;
    phase_t            src, snk;
    logic              valid;
    logic [PHASES-1:0] src_m, snk_m;

    always_comb begin
        fp    = fwd_pair(hall_i);
        valid = (fp.src != PH_NONE);
        src   = dir_f ? fp.src : fp.snk;
        snk   = dir_f ? fp.snk : fp.src;
        src_m = phase_mask(src);
        snk_m = phase_mask(snk);

        want_hs_o = '0;
        want_ls_o = '0;
        standby_o = stop_f & brake_f;

        if (standby_o || fault_i || stop_f || !valid) begin
            want_hs_o = '0;
            want_ls_o = '0;
        end else if (brake_f) begin
            want_ls_o = '1;
        end else if (chop_f) begin
            want_hs_o = src_m;
            want_ls_o = snk_m;
        end else begin
            want_ls_o = snk_m | (ovp_i ? '0 : src_m);
        end
    end

endmodule

// File: rtl/bldc_deadtime_leg.sv
module bldc_deadtime_leg #(
    parameter int unsigned DEAD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hs_i,
    input  logic want_ls_i,
    output logic hs_o,
    output logic ls_o
);
    localparam int unsigned CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

    typedef struct packed {
        logic          hs;
        logic          ls;
        logic [CW-1:0] cnt;
    } leg_state_t;

    leg_state_t st_d, st_q;
    logic       quiet;

    always_comb begin
        quiet  = (st_q.cnt == '0);
        st_d   = st_q;
        st_d.hs = want_hs_i && !want_ls_i && (st_q.hs || (!st_q.ls && quiet));
        st_d.ls = want_ls_i && !want_hs_i && (st_q.ls || (!st_q.hs && quiet));
        if ((st_q.hs && !st_d.hs) || (st_q.ls && !st_d.ls)) begin
            st_d.cnt = RELOAD;
        end else if (!quiet) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hs: 1'b0, ls: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_o = st_q.hs;
    assign ls_o = st_q.ls;

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int unsigned CHOP_FILT = 100,
    parameter int unsigned CTRL_FILT = 200,
    parameter int unsigned DEAD_CYC  = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    input  logic       dir_i,
    input  logic       stop_i,
    input  logic       brake_i,
    input  logic       chop_i,
    input  logic       ovp_i,
    input  logic       tsd_i,
    input  logic       uv_i,
    output logic [2:0] hs_en_o,
    output logic [2:0] ls_en_o,
    output logic       standby_o
);
    localparam int unsigned NFILT = 4;   // 0 chop, 1 dir, 2 stop, 3 brake

    logic [NFILT-1:0]  raw_v, flt_v;
    logic [PHASES-1:0] want_hs, want_ls;

    assign raw_v = {brake_i, stop_i, dir_i, chop_i};

    for (genvar g = 0; g < NFILT; g++) begin : g_filt
        bldc_glitch_filter #(
            .LEN     ((g == 0) ? CHOP_FILT : CTRL_FILT),
            .RST_VAL ((g == 2) ? 1'b1 : 1'b0)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_v[g]),
            .flt_o (flt_v[g])
        );
    end

    bldc_commutation_table u_table (
        .hall_i    (hall_i),
        .dir_f     (flt_v[1]),
        .stop_f    (flt_v[2]),
        .brake_f   (flt_v[3]),
        .chop_f    (flt_v[0]),
        .ovp_i     (ovp_i),
        .fault_i   (tsd_i | uv_i),
        .want_hs_o (want_hs),
        .want_ls_o (want_ls),
        .standby_o (standby_o)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        bldc_deadtime_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk       (clk),
            .rst_n     (rst_n),
            .want_hs_i (want_hs[p]),
            .want_ls_i (want_ls[p]),
            .hs_o      (hs_en_o[p]),
            .ls_o      (ls_en_o[p])
        );
    end

endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk #(
    parameter int unsigned DEAD_CYC = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall_i,
    input logic       tsd_i,
    input logic       uv_i,
    input logic [2:0] hs_en_o,
    input logic [2:0] ls_en_o,
    input logic       standby_o
);
    localparam int unsigned GW = $clog2(DEAD_CYC + 1);
    localparam logic [GW-1:0] GMAX = GW'(DEAD_CYC);

    logic [GW-1:0] gap_q [3];

    for (genvar p = 0; p < 3; p++) begin : g_gap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gap_q[p] <= GMAX;
            end else if (hs_en_o[p] || ls_en_o[p]) begin
                gap_q[p] <= '0;
            end else if (gap_q[p] != GMAX) begin
                gap_q[p] <= gap_q[p] + 1'b1;
            end
        end

        // R9: both switches of a leg are never on together
        a_r9_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
            !(hs_en_o[p] && ls_en_o[p]));

        // R9: a high side turns on only after a full dead gap
        a_r9_hs_gap: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hs_en_o[p]) |-> (gap_q[p] == GMAX));

        // R9: a low side turns on only after a full dead gap
        a_r9_ls_gap: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ls_en_o[p]) |-> (gap_q[p] == GMAX));
    end

    a_r6_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_o && $past(standby_o)) |-> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

    a_r11_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tsd_i || uv_i) |-> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

    a_r3_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hall_i == 3'b000 || hall_i == 3'b111) |-> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

endmodule

bind bldc_commutator bldc_commutator_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall_i    (hall_i),
    .tsd_i     (tsd_i),
    .uv_i      (uv_i),
    .hs_en_o   (hs_en_o),
    .ls_en_o   (ls_en_o),
    .standby_o (standby_o)
);

// File: tb/bldc_commutator_bench.sv
module bldc_commutator_bench;
    localparam int CHOP_FILT = 4;
    localparam int CTRL_FILT = 8;
    localparam int DEAD_CYC  = 3;
    localparam int SETTLE    = CTRL_FILT + 2 * DEAD_CYC + 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall = 3'b101;
    logic       dir = 1'b1, stop = 1'b0, brake = 1'b0, chop = 1'b1;
    logic       ovp = 1'b0, tsd = 1'b0, uv = 1'b0;
    logic [2:0] hs, ls;
    logic       stby;

    int checks = 0, failures = 0, dt_viol = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bldc_commutator #(
        .CHOP_FILT(CHOP_FILT), .CTRL_FILT(CTRL_FILT), .DEAD_CYC(DEAD_CYC)
    ) u_bldc_commutator (
        .clk(clk), .rst_n(rst_n), .hall_i(hall), .dir_i(dir), .stop_i(stop),
        .brake_i(brake), .chop_i(chop), .ovp_i(ovp), .tsd_i(tsd), .uv_i(uv),
        .hs_en_o(hs), .ls_en_o(ls), .standby_o(stby)
    );

    // Expected {standby, hs[2:0], ls[2:0]} for settled inputs
    function automatic logic [6:0] model(input logic [2:0] h, input logic d, input logic s,
                                          input logic b, input logic c, input logic o,
                                          input logic f);
        logic [2:0] codes [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        int hi_ph [6] = '{0, 0, 1, 1, 2, 2};
        int lo_ph [6] = '{1, 2, 2, 0, 0, 1};
        int k = -1;
        int a, z;
        logic [2:0] eh, el;
        for (int i = 0; i < 6; i++) if (codes[i] == h) k = i;
        eh = 3'b000; el = 3'b000;
        if (s && b) return 7'b1_000_000;
        if (f || s || k < 0) return 7'b0_000_000;
        if (b) return 7'b0_000_111;
        a = d ? hi_ph[k] : lo_ph[k];
        z = d ? lo_ph[k] : hi_ph[k];
        if (c) begin
            eh[a] = 1'b1; el[z] = 1'b1;
        end else begin
            el[z] = 1'b1;
            if (!o) el[a] = 1'b1;
        end
        return {1'b0, eh, el};
    endfunction

    function automatic logic [6:0] expect_now();
        return model(hall, dir, stop, brake, chop, ovp, tsd | uv);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic settle_check(input string tag);
        logic [6:0] e;
        repeat (SETTLE) @(negedge clk);
        e = expect_now();
        chk({stby, hs, ls} == e, tag, {stby, hs, ls}, e);
    endtask

    // Independent dead-time monitor
    int gap [3];
    logic [2:0] hs_p = 3'b000, ls_p = 3'b000;
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 3; p++) gap[p] = 1000;
        end else begin
            for (int p = 0; p < 3; p++) begin
                if (hs[p] && ls[p]) dt_viol++;
                if ((hs[p] && !hs_p[p]) || (ls[p] && !ls_p[p])) begin
                    if (gap[p] < DEAD_CYC) dt_viol++;
                end
                if (hs[p] || ls[p]) gap[p] = 0;
                else if (gap[p] < 1000) gap[p]++;
            end
        end
        hs_p = hs; ls_p = ls;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [6:0] e0;
        bit ok;
        void'($urandom(32'd4321));

        // R12 reset state
        repeat (4) @(negedge clk);
        chk({stby, hs, ls} == 7'd0, "R12 in reset", {stby, hs, ls}, 7'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({stby, hs, ls} == 7'd0, "R12 after reset", {stby, hs, ls}, 7'd0);

        // R1 forward sequence
        foreach (hall[i]) ;
        for (int k = 0; k < 6; k++) begin
            logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
            hall = seq[k]; dir = 1'b1;
            settle_check("R1 forward step");
        end
        // R2 reverse sequence
        for (int k = 0; k < 6; k++) begin
            logic [2:0] seq [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
            hall = seq[k]; dir = 1'b0;
            settle_check("R2 reverse step");
        end
        dir = 1'b1;

        // R3 invalid codes, also under brake
        hall = 3'b000; settle_check("R3 code 000");
        hall = 3'b111; settle_check("R3 code 111");
        brake = 1'b1;  settle_check("R3 code 111 with brake");
        brake = 1'b0; hall = 3'b110;

        // R4 stop, R5 brake, each with chop low
        stop = 1'b1; chop = 1'b0; settle_check("R4 stop with chop low");
        stop = 1'b0; brake = 1'b1; settle_check("R5 brake with chop low");
        brake = 1'b0; chop = 1'b1; settle_check("R1 recover");

        // R7 decay, R8 overvoltage
        chop = 1'b0; settle_check("R7 slow decay");
        ovp = 1'b1;  settle_check("R8 decay blocked by overvoltage");
        ovp = 1'b0; chop = 1'b1; settle_check("R7 drive after decay");

        // R6 standby with other inputs moving
        stop = 1'b1; brake = 1'b1;
        settle_check("R6 enter standby");
        ok = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            hall = 3'($urandom_range(0, 7)); dir = ~dir; chop = ~chop;
            ovp = k[0]; tsd = k[1]; uv = k[2];
            if ({stby, hs, ls} != 7'b1_000_000) ok = 1'b0;
        end
        chk(ok, "R6 inputs ignored in standby", {stby, hs, ls}, 7'b1_000_000);
        tsd = 1'b0; uv = 1'b0; ovp = 1'b0; dir = 1'b1; chop = 1'b1; hall = 3'b011;
        stop = 1'b0; brake = 1'b0;
        settle_check("R6 leave standby");

        // R11 faults take effect at the next edge
        tsd = 1'b1; @(negedge clk);
        chk({hs, ls} == 6'd0, "R11 thermal next edge", {stby, hs, ls}, 7'd0);
        tsd = 1'b0; settle_check("R11 thermal released");
        uv = 1'b1; @(negedge clk);
        chk({hs, ls} == 6'd0, "R11 undervoltage next edge", {stby, hs, ls}, 7'd0);
        uv = 1'b0; hall = 3'b101; settle_check("R11 undervoltage released");

        // R10 glitch filters
        e0 = expect_now();
        ok = 1'b1; chop = 1'b0;
        for (int k = 0; k < CHOP_FILT + 6; k++) begin
            @(negedge clk);
            if (k == CHOP_FILT - 2) chop = 1'b1;
            if ({stby, hs, ls} != e0) ok = 1'b0;
        end
        chk(ok, "R10 short chop pulse", {stby, hs, ls}, e0);
        chop = 1'b0;
        for (int k = 0; k <= CHOP_FILT; k++) begin
            @(negedge clk);
            if (k == CHOP_FILT - 1) chop = 1'b1;
        end
        chk(hs == 3'b000, "R10 full chop pulse", {stby, hs, ls}, {1'b0, 3'b000, ls});
        settle_check("R10 after chop pulse");

        foreach (e0[i]) ;
        for (int w = 0; w < 3; w++) begin
            e0 = expect_now();
            ok = 1'b1;
            if (w == 0) stop = 1'b1; else if (w == 1) brake = 1'b1; else dir = 1'b0;
            for (int k = 0; k < CTRL_FILT + 6; k++) begin
                @(negedge clk);
                if (k == CTRL_FILT - 2) begin stop = 1'b0; brake = 1'b0; dir = 1'b1; end
                if ({stby, hs, ls} != e0) ok = 1'b0;
            end
            chk(ok, "R10 short control pulse", {stby, hs, ls}, e0);
        end
        stop = 1'b1;
        for (int k = 0; k <= CTRL_FILT; k++) begin
            @(negedge clk);
            if (k == CTRL_FILT - 1) stop = 1'b0;
        end
        chk({hs, ls} == 6'd0, "R10 full stop pulse", {stby, hs, ls}, 7'd0);
        settle_check("R10 after stop pulse");

        // Random patterns covering R1 R2 R3 R4 R5 R7 R8 R11
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            hall  = ($urandom_range(0, 9) == 0) ? (($urandom_range(0, 1) != 0) ? 3'b111 : 3'b000)
                                                : 3'($urandom_range(1, 6));
            dir   = 1'($urandom_range(0, 1));
            stop  = ($urandom_range(0, 6) == 0);
            brake = ($urandom_range(0, 6) == 0);
            chop  = ($urandom_range(0, 9) < 7);
            ovp   = ($urandom_range(0, 4) == 0);
            tsd   = ($urandom_range(0, 19) == 0);
            uv    = ($urandom_range(0, 19) == 0);
            settle_check("RND R1 R2 R3 R4 R5 R7 R8 R11");
        end

        chk(dt_viol == 0, "R9 dead-time monitor", 7'(dt_viol), 7'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule